// File: doc/BRIEF.md
# Redundant-Form Modular Multiplier

This block forms the product of two operands reduced by a modulus, `prod = x*y mod m`, for a K-bit modulus. It walks the multiplier from its most significant bit down. For each bit it doubles a running partial value and then, when the bit is one, adds the multiplicand. The partial value is never resolved into a single binary word during the loop. It is kept as a sum word and a carry word, each K+2 bits wide, and each of those words is updated by one layer of full adders. Every doubling, and every add step, is followed by one reduction step. That step folds in -m, zero or +m, and the choice is guessed from a 4-bit sum of the two words' top bits.

Once all K bits have been processed, a single carry-propagate addition merges the two words. If that sum is negative, one more addition of m brings it into the range 0 to m-1. The caller pulses `start` with the operands present, then waits for the one-cycle `done` pulse. The result stays on `prod` until the next operation finishes. The modulus must be normalised, with its top bit set, and both operands must be below it.

Top module: `csa_modmul`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `prod` is 0 until the first operation finishes.
- R2: For 2^(K-1) <= m < 2^K and x, y < m, the value on `prod` when `done` is high equals (x*y) mod m.
- R3: A zero multiplier or a zero multiplicand yields `prod` = 0.
- R4: Operands equal to m-1 yield ((m-1)*(m-1)) mod m = 1, and a multiplier of 1 yields y.
- R5: `done` rises exactly 2K+1 clock edges after the edge that samples `start` high: one doubling cycle and one add cycle per multiplier bit, plus one cycle for the final merge and correction.
- R6: `done` is high for exactly one cycle per operation.
- R7: A `start` pulse while an operation is in progress has no effect. The running operation's result is unchanged, and no extra `done` follows it.
- R8: `prod` keeps its value between operations until the next `done`.
- R9: The redundant partial value, read as a signed (K+2)-bit sum of the two words, stays within [-m, m) at every step. This also holds at the extremes m = 2^(K-1) and m = 2^K - 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the operands present; sampled only when idle |
| x_in | input | K | Multiplier, scanned from its top bit |
| y_in | input | K | Multiplicand |
| mod_in | input | K | Modulus with its top bit set |
| done | output | 1 | One-cycle pulse when `prod` is valid |
| prod | output | K | Reduced product, held until the next completion |

## Verification
The bench samples `start` on one rising edge and then counts rising edges until `done` is seen. It requires the count to be exactly 2K+1, and it reads `prod` in that same cycle. On the following cycle it checks that `done` has dropped. After an operation that was disturbed by a second `start`, the bench waits a further 2K+8 cycles. During that window it requires `done` to stay low and `prod` to keep its value, so that a wrongly accepted restart would appear inside the window. All sampling happens on the falling edge, halfway between the edges that update the outputs.

// File: rtl/csa_modmul.sv
module csa_modmul #(
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] x_in,
  input  logic [K-1:0] y_in,
  input  logic [K-1:0] mod_in,
  output logic         done,
  output logic [K-1:0] prod
);
  localparam int W  = K + 2;
  localparam int CW = $clog2(K + 1);

  typedef enum logic [1:0] {S_IDLE, S_DBL, S_ADD, S_FIN} st_t;

  st_t           st;
  logic [W-1:0]  ps, pc;
  logic [K-1:0]  xr, yr, mr;
  logic [CW-1:0] cnt;

  logic [W-1:0] mext, mneg, yadd;
  assign mext = {2'b00, mr};
  assign mneg = ~mext + 1'b1;
  assign yadd = xr[K-1] ? {2'b00, yr} : '0;

  // add stage: one full-adder layer folding y into the pair
  logic [W-1:0] a_s, a_mj;
  assign a_s  = ps ^ pc ^ yadd;
  assign a_mj = (ps & pc) | (ps & yadd) | (pc & yadd);

  // pair entering the reduction step
  logic [W-1:0] r_s, r_c;
  assign r_s = (st == S_ADD) ? a_s : {ps[W-2:0], 1'b0};
  assign r_c = (st == S_ADD) ? {a_mj[W-2:0], 1'b0} : {pc[W-2:0], 1'b0};

  // quotient digit from the top four bits of both words
  logic [3:0] est;
  logic       q_sub, q_add;
  assign est   = r_s[W-1:W-4] + r_c[W-1:W-4];
  assign q_sub = ~est[3] & (est != 4'd0);
  assign q_add = est[3] & (est != 4'hF);

  logic [W-1:0] rd, n_s, n_mj;
  assign rd   = q_sub ? mneg : (q_add ? mext : '0);
  assign n_s  = r_s ^ r_c ^ rd;
  assign n_mj = (r_s & r_c) | (r_s & rd) | (r_c & rd);

  // final merge and sign correction
  logic [K:0]   tot;
  logic [K-1:0] fixed;
  assign tot   = ps[K:0] + pc[K:0];
  assign fixed = tot[K] ? (tot[K-1:0] + mr) : tot[K-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ps   <= '0;
      pc   <= '0;
      xr   <= '0;
      yr   <= '0;
      mr   <= '0;
      cnt  <= '0;
      done <= 1'b0;
      prod <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          xr  <= x_in;
          yr  <= y_in;
          mr  <= mod_in;
          ps  <= '0;
          pc  <= '0;
          cnt <= '0;
          st  <= S_DBL;
        end
        S_DBL: begin
          ps <= n_s;
          pc <= {n_mj[W-2:0], 1'b0};
          st <= S_ADD;
        end
        S_ADD: begin
          ps  <= n_s;
          pc  <= {n_mj[W-2:0], 1'b0};
          xr  <= {xr[K-2:0], 1'b0};
          cnt <= cnt + 1'b1;
          st  <= (cnt == CW'(K - 1)) ? S_FIN : S_DBL;
        end
        default: begin
          prod <= fixed;
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  logic [W-1:0] red_sum;
  assign red_sum = ps + pc;

  assert_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> ($signed(red_sum) < $signed(mext)) &&
                       ($signed(red_sum) >= -$signed(mext)));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prod < mr));

  assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> ($stable(mr) && $stable(yr)));

  assert_prod_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (!done -> $stable(prod)));

endmodule

// File: tb/csa_modmul_test.sv
`timescale 1ns/1ps
module csa_modmul_test;
  localparam int K  = 16;
  localparam int NV = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [K-1:0] x_in = '0, y_in = '0, mod_in = '0;
  logic         done;
  logic [K-1:0] prod;

  int checks = 0;
  int fails  = 0;

  csa_modmul #(.K(K)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .mod_in(mod_in),
    .done(done), .prod(prod)
  );

  always #4 clk = ~clk;

  // {x, y, m}
  localparam logic [47:0] VEC [NV] = '{
    {16'h0003, 16'h0005, 16'h8003},
    {16'h1234, 16'h0FED, 16'hC001},
    {16'h0000, 16'h7777, 16'h9999},
    {16'h4444, 16'h0000, 16'hA5A5},
    {16'hFFFE, 16'hFFFE, 16'hFFFF},
    {16'h7FFF, 16'h7FFF, 16'h8000},
    {16'h0001, 16'hFFFE, 16'hFFFF},
    {16'h8000, 16'h8000, 16'h8001},
    {16'hABCD, 16'h1357, 16'hFFF1},
    {16'hDEAD, 16'hBEEF, 16'hE001},
    {16'h0001, 16'h0001, 16'h8000},
    {16'h9000, 16'hF000, 16'hF00F}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [K-1:0] x, input logic [K-1:0] y,
                        input logic [K-1:0] m, input bit poke, input string req);
    longint exp;
    int lat;
    logic [K-1:0] held;
    exp = (longint'(x) * longint'(y)) % longint'(m);
    @(negedge clk);
    x_in = x; y_in = y; mod_in = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 4) begin
        start = 1'b1; x_in = ~x; y_in = 16'h0001; mod_in = 16'h8001;
      end else start = 1'b0;
    end
    start = 1'b0;
    chk(lat == 2*K+1, "R5", lat, 2*K+1);
    chk(prod == exp[K-1:0], req, prod, exp);
    held = prod;
    @(negedge clk);
    chk(done == 1'b0, "R6", done, 0);
    if (poke) begin
      bit extra = 1'b0;
      for (int c = 0; c < 2*K+8; c++) begin
        @(negedge clk);
        if (done) extra = 1'b1;
      end
      chk(!extra, "R7", extra, 0);
      chk(prod == held, "R8", prod, held);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", done, 0);
    chk(prod == '0, "R1", prod, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R1", done, 0);
    chk(prod == '0, "R1", prod, 0);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], 1'b0, "R2");

    // corner cases
    run_op(16'h0000, 16'hFFFE, 16'hFFFF, 1'b0, "R3");
    run_op(16'hC123, 16'h0000, 16'hFFFF, 1'b0, "R3");
    run_op(16'hFFFE, 16'hFFFE, 16'hFFFF, 1'b0, "R4");
    run_op(16'h7FFF, 16'h7FFF, 16'h8000, 1'b0, "R4");
    run_op(16'h0001, 16'h6789, 16'h9001, 1'b0, "R4");
    run_op(16'hFFFD, 16'hFFFC, 16'hFFFF, 1'b0, "R9");
    run_op(16'h7FFE, 16'h7FFD, 16'h8000, 1'b0, "R9");

    // start while busy
    run_op(16'hBEEF, 16'h1234, 16'hC0DE, 1'b1, "R7");
    run_op(16'h0000, 16'h0000, 16'h8001, 1'b1, "R7");

    for (int i = 0; i < 150; i++) begin
      logic [K-1:0] m, x, y;
      m = K'($urandom) | 16'h8000;
      x = K'($urandom % m);
      y = K'($urandom % m);
      run_op(x, y, m, 1'b0, "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule